// File: doc/BRIEF.md
# Sound Channel Length and Status Tracker

This block follows the register writes made to a five-voice sound unit and keeps only the control state around each voice's note duration. The voices are two pulse voices, one triangle voice, one noise voice and one sample-playback voice. Each voice has an enable flag and a down-counting length, and the block reports whether each voice is still sounding. No waveform is produced here. The block also keeps the triangle's linear counter, the sample voice's rate, loop and interrupt setup, and a small frame-sequencer state that raises a frame interrupt.

Writes arrive one per cycle as a 5-bit register offset and an 8-bit value. Offsets 0x00 to 0x13 are the voice registers, four per voice in the order pulse 0, pulse 1, triangle, noise, sample. Offset 0x15 is the voice enable mask, 0x17 sets the frame mode, and 0x18 is a frame-step strobe. Elsewhere in the chip, a sequencer drives the frame-step strobe. Bit 0 of each strobe value blocks the length counters on that step.

Top module: `snd_len_status`

## Requirements
- R1: After a synchronous reset every output is zero and every voice is disabled with zero length and linear count.
- R2: A write to the fourth register (offset base+3) of pulse 0, pulse 1, triangle or noise loads that voice's length with twice the table entry selected by data bits 7:3 (table 5,127,10,1,19,2,40,3,80,4,30,5,7,6,13,7,6,8,12,9,24,10,48,11,96,12,36,13,8,14,16,15). It enables the voice only if the matching bit of the last 0x15 write is 1 (bit 0 pulse 0, bit 1 pulse 1, bit 2 triangle, bit 3 noise, bit 4 sample). ch_active[i] is 1 when voice i is enabled and its count is nonzero.
- R3: Writing 0x15 with a voice bit at 0 forces that voice's enable and length to zero. For the triangle it also zeroes the linear count and the reload flag.
- R4: The halt flag is bit 5 of register 0 for the pulse and noise voices, and bit 7 of register 0 for the triangle. A halted voice keeps its length on frame steps.
- R5: On a frame step, a length count drops by one only if the voice is enabled, the count is nonzero, the voice is not halted and step bit 0 is 0.
- R6: On a frame step of an enabled triangle, the linear count reloads from register 0 bits 6:0 when the reload flag is set, and otherwise drops toward zero. A register-3 load sets the reload flag. After the step the flag clears if the triangle is not halted and the new linear count is nonzero.
- R7: A write to 0x10 sets sample_period to eight times the rate entry selected by bits 3:0 (428,380,340,320,286,254,226,214,190,160,142,128,106,85,72,54). It also sets sample_loop from bit 6 and sample_irq_arm from bit 7.
- R8: A write to 0x13 stores a sample length of data*16+1. Writing 0x15 with bit 4 set enables the sample voice and, only if its remaining count is zero, copies the stored length into it. Writing bit 4 at 0 clears the enable, the remaining count and sample_irq_arm.
- R9: A write to 0x17 clears frame_irq, sets frame_five_step from bit 7, and makes the next strobe step 1 of a 4-step cycle. When bit 7 is 1 it also performs one immediate frame step with step bit 0 taken as 0.
- R10: A 0x18 strobe at step 0 of the cycle raises frame_irq only when the last 0x17 bits 7 and 6 were both 0 and frame_irq_en is 1. Every 0x18 strobe advances the step.
- R11: sample_irq_clr pulses for one cycle, one cycle after a 0x10 write with bit 7 at 0 or a 0x15 write with bit 4 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register offset |
| wr_data | input | 8 | Write value |
| frame_irq_en | input | 1 | Allows frame interrupts |
| ch_active | output | 5 | Per-voice sounding flags |
| tri_linear | output | 7 | Triangle linear count |
| frame_irq | output | 1 | Frame interrupt |
| sample_irq_clr | output | 1 | One-cycle sample interrupt clear |
| sample_period | output | 12 | Sample rate period in clocks |
| sample_loop | output | 1 | Sample loop flag |
| sample_irq_arm | output | 1 | Sample interrupt enabled |
| frame_five_step | output | 1 | Five-step frame mode |

## Verification
The hardest case to reach is the triangle reload flag held by a halt. The reload flag cannot be seen at the ports, so the stimulus loads the triangle once with halt clear and once with halt set. It then watches tri_linear over several steps: without halt the count runs down after one reload, and with halt it stays pinned at the reload value. The frame interrupt needs exactly four strobes after a mode write, so the bench counts strobes from each 0x17 write. It checks the plain mode, the inhibit bit, the five-step mode and frame_irq_en low. A reference model follows every write and is compared against every output on each clock.

// File: rtl/snd_len_pkg.sv
package snd_len_pkg;
  localparam logic [4:0] A_STATUS = 5'h15;
  localparam logic [4:0] A_FRAME  = 5'h17;
  localparam logic [4:0] A_STEP   = 5'h18;
  localparam logic [4:0] A_SMP_R0 = 5'h10;
  localparam logic [4:0] A_SMP_R3 = 5'h13;

  function automatic logic [6:0] len_lookup(input logic [4:0] idx);
    case (idx)
      5'd0:  return 7'd5;   5'd1:  return 7'd127; 5'd2:  return 7'd10;  5'd3:  return 7'd1;
      5'd4:  return 7'd19;  5'd5:  return 7'd2;   5'd6:  return 7'd40;  5'd7:  return 7'd3;
      5'd8:  return 7'd80;  5'd9:  return 7'd4;   5'd10: return 7'd30;  5'd11: return 7'd5;
      5'd12: return 7'd7;   5'd13: return 7'd6;   5'd14: return 7'd13;  5'd15: return 7'd7;
      5'd16: return 7'd6;   5'd17: return 7'd8;   5'd18: return 7'd12;  5'd19: return 7'd9;
      5'd20: return 7'd24;  5'd21: return 7'd10;  5'd22: return 7'd48;  5'd23: return 7'd11;
      5'd24: return 7'd96;  5'd25: return 7'd12;  5'd26: return 7'd36;  5'd27: return 7'd13;
      5'd28: return 7'd8;   5'd29: return 7'd14;  5'd30: return 7'd16;  default: return 7'd15;
    endcase
  endfunction

  function automatic logic [8:0] rate_lookup(input logic [3:0] sel);
    case (sel)
      4'd0:  return 9'd428; 4'd1:  return 9'd380; 4'd2:  return 9'd340; 4'd3:  return 9'd320;
      4'd4:  return 9'd286; 4'd5:  return 9'd254; 4'd6:  return 9'd226; 4'd7:  return 9'd214;
      4'd8:  return 9'd190; 4'd9:  return 9'd160; 4'd10: return 9'd142; 4'd11: return 9'd128;
      4'd12: return 9'd106; 4'd13: return 9'd85;  4'd14: return 9'd72;  default: return 9'd54;
    endcase
  endfunction
endpackage

// File: rtl/snd_len_chan.sv
module snd_len_chan
  import snd_len_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg0_wr,
  input  logic       halt_in,
  input  logic       reg3_wr,
  input  logic [4:0] len_idx,
  input  logic       stat_en,
  input  logic       stat_wr,
  input  logic       stat_bit,
  input  logic       step_ev,
  input  logic       step_b0,
  output logic       active
);
  logic             en_q;
  logic             halt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] load_val;

  assign load_val = LEN_W'({len_lookup(len_idx), 1'b0});
  assign active   = en_q && (len_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      halt_q <= 1'b0;
      len_q  <= '0;
    end else begin
      if (reg0_wr) halt_q <= halt_in;
      if (reg3_wr) begin
        len_q <= load_val;
        if (stat_en) en_q <= 1'b1;
      end
      if (stat_wr && !stat_bit) begin
        en_q  <= 1'b0;
        len_q <= '0;
      end
      if (step_ev && en_q && (len_q != '0) && !halt_q && !step_b0)
        len_q <= len_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/snd_tri_chan.sv
module snd_tri_chan
  import snd_len_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int LIN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg0_wr,
  input  logic             halt_in,
  input  logic [LIN_W-1:0] relv_in,
  input  logic             reg3_wr,
  input  logic [4:0]       len_idx,
  input  logic             stat_en,
  input  logic             stat_wr,
  input  logic             stat_bit,
  input  logic             step_ev,
  input  logic             step_b0,
  output logic             active,
  output logic [LIN_W-1:0] lin
);
  logic             en_q, halt_q, rel_q;
  logic [LEN_W-1:0] len_q;
  logic [LIN_W-1:0] relv_q, lin_q, lin_nx;

  assign active = en_q && (len_q != '0);
  assign lin    = lin_q;
  assign lin_nx = rel_q ? relv_q : ((lin_q != '0) ? lin_q - LIN_W'(1) : lin_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; halt_q <= 1'b0; rel_q <= 1'b0;
      len_q <= '0; relv_q <= '0; lin_q <= '0;
    end else begin
      if (reg0_wr) begin
        halt_q <= halt_in;
        relv_q <= relv_in;
      end
      if (reg3_wr) begin
        len_q <= LEN_W'({len_lookup(len_idx), 1'b0});
        rel_q <= 1'b1;
        if (stat_en) en_q <= 1'b1;
      end
      if (stat_wr && !stat_bit) begin
        en_q <= 1'b0; len_q <= '0; lin_q <= '0; rel_q <= 1'b0;
      end
      if (step_ev && en_q) begin
        if (!halt_q && !step_b0 && (len_q != '0)) len_q <= len_q - LEN_W'(1);
        lin_q <= lin_nx;
        if (!halt_q && (lin_nx != '0)) rel_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snd_smp_chan.sv
module snd_smp_chan
  import snd_len_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg0_wr,
  input  logic             reg3_wr,
  input  logic [7:0]       wr_data,
  input  logic             stat_wr,
  output logic             active,
  output logic [PER_W-1:0] period,
  output logic             loop_f,
  output logic             irq_arm,
  output logic             irq_clr
);
  logic             en_q;
  logic [CNT_W-1:0] cache_q, rem_q;

  assign active = en_q && (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; cache_q <= '0; rem_q <= '0;
      period <= '0; loop_f <= 1'b0; irq_arm <= 1'b0; irq_clr <= 1'b0;
    end else begin
      irq_clr <= (reg0_wr && !wr_data[7]) || (stat_wr && !wr_data[4]);
      if (reg0_wr) begin
        period  <= PER_W'({rate_lookup(wr_data[3:0]), 3'b000});
        loop_f  <= wr_data[6];
        irq_arm <= wr_data[7];
      end
      if (reg3_wr) cache_q <= CNT_W'({wr_data, 4'b0000}) + CNT_W'(1);
      if (stat_wr) begin
        if (!wr_data[4]) begin
          en_q <= 1'b0; rem_q <= '0; irq_arm <= 1'b0;
        end else begin
          en_q <= 1'b1;
          if (rem_q == '0) rem_q <= cache_q;
        end
      end
    end
  end
endmodule

// File: rtl/snd_frame_ctl.sv
module snd_frame_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [1:0] mode_in,
  input  logic       step_wr,
  input  logic       irq_en,
  output logic       irq,
  output logic       five_step
);
  logic [1:0] mode_q, cnt_q;

  assign five_step = mode_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'b00; cnt_q <= 2'd0; irq <= 1'b0;
    end else if (ctl_wr) begin
      irq    <= 1'b0;
      mode_q <= mode_in;
      cnt_q  <= 2'd1;
    end else if (step_wr) begin
      if ((cnt_q == 2'd0) && (mode_q == 2'b00) && irq_en) irq <= 1'b1;
      cnt_q <= cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/snd_len_status.sv
module snd_len_status
  import snd_len_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int LIN_W = 7,
  parameter int CNT_W = 12,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [4:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             frame_irq_en,
  output logic [4:0]       ch_active,
  output logic [LIN_W-1:0] tri_linear,
  output logic             frame_irq,
  output logic             sample_irq_clr,
  output logic [PER_W-1:0] sample_period,
  output logic             sample_loop,
  output logic             sample_irq_arm,
  output logic             frame_five_step
);
  localparam int NUM_TONE = 4;

  logic [NUM_TONE-1:0] status_q;
  logic                stat_wr, frame_wr, step_wr, step_ev, step_b0;

  assign stat_wr  = wr_en && (wr_addr == A_STATUS);
  assign frame_wr = wr_en && (wr_addr == A_FRAME);
  assign step_wr  = wr_en && (wr_addr == A_STEP);
  assign step_ev  = step_wr || (frame_wr && wr_data[7]);
  assign step_b0  = step_wr && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else if (stat_wr) status_q <= wr_data[NUM_TONE-1:0];
  end

  for (genvar gi = 0; gi < NUM_TONE; gi++) begin : g_ch
    localparam logic [4:0] BASE = 5'(gi * 4);
    logic r0_wr, r3_wr;
    assign r0_wr = wr_en && (wr_addr == BASE);
    assign r3_wr = wr_en && (wr_addr == BASE + 5'd3);
    if (gi == 2) begin : g_tri
      snd_tri_chan #(.LEN_W(LEN_W), .LIN_W(LIN_W)) u_tri (
        .clk(clk), .rst(rst), .reg0_wr(r0_wr), .halt_in(wr_data[7]),
        .relv_in(wr_data[LIN_W-1:0]), .reg3_wr(r3_wr), .len_idx(wr_data[7:3]),
        .stat_en(status_q[gi]), .stat_wr(stat_wr), .stat_bit(wr_data[gi]),
        .step_ev(step_ev), .step_b0(step_b0), .active(ch_active[gi]), .lin(tri_linear)
      );
    end else begin : g_len
      snd_len_chan #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst(rst), .reg0_wr(r0_wr), .halt_in(wr_data[5]),
        .reg3_wr(r3_wr), .len_idx(wr_data[7:3]),
        .stat_en(status_q[gi]), .stat_wr(stat_wr), .stat_bit(wr_data[gi]),
        .step_ev(step_ev), .step_b0(step_b0), .active(ch_active[gi])
      );
    end
  end

  snd_smp_chan #(.CNT_W(CNT_W), .PER_W(PER_W)) u_smp (
    .clk(clk), .rst(rst),
    .reg0_wr(wr_en && (wr_addr == A_SMP_R0)), .reg3_wr(wr_en && (wr_addr == A_SMP_R3)),
    .wr_data(wr_data), .stat_wr(stat_wr), .active(ch_active[4]),
    .period(sample_period), .loop_f(sample_loop), .irq_arm(sample_irq_arm),
    .irq_clr(sample_irq_clr)
  );

  snd_frame_ctl u_frame (
    .clk(clk), .rst(rst), .ctl_wr(frame_wr), .mode_in(wr_data[7:6]),
    .step_wr(step_wr), .irq_en(frame_irq_en), .irq(frame_irq), .five_step(frame_five_step)
  );
endmodule

// File: rtl/snd_len_status_chk.sv
module snd_len_status_chk #(
  parameter int LIN_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [4:0]       wr_addr,
  input logic             wd1,
  input logic             wd6,
  input logic             wd7,
  input logic             act0,
  input logic             act1,
  input logic             act4,
  input logic [LIN_W-1:0] tri_linear,
  input logic             frame_irq,
  input logic             sample_irq_clr,
  input logic             sample_loop,
  input logic             sample_irq_arm,
  input logic             frame_five_step
);
  assert_pulse_arm_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(act0) |-> $past(wr_en && wr_addr == 5'h03));

  assert_status_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 5'h15 && !wd1) |=> !act1);

  assert_lin_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (tri_linear > $past(tri_linear)) |-> $past(wr_en && (wr_addr == 5'h18 || wr_addr == 5'h17)));

  assert_sample_setup_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 5'h10) |=> (sample_loop == $past(wd6) && sample_irq_arm == $past(wd7)));

  assert_sample_arm_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(act4) |-> $past(wr_en && wr_addr == 5'h15));

  assert_mode_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 5'h17) |=> (!frame_irq && frame_five_step == $past(wd7)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_irq) |-> $past(wr_en && wr_addr == 5'h18));

  assert_clr_source_R11: assert property (@(posedge clk) disable iff (rst)
    sample_irq_clr |-> $past(wr_en && (wr_addr == 5'h15 || wr_addr == 5'h10)));
endmodule

bind snd_len_status snd_len_status_chk #(.LIN_W(LIN_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wd1(wr_data[1]), .wd6(wr_data[6]), .wd7(wr_data[7]),
  .act0(ch_active[0]), .act1(ch_active[1]), .act4(ch_active[4]),
  .tri_linear(tri_linear), .frame_irq(frame_irq), .sample_irq_clr(sample_irq_clr),
  .sample_loop(sample_loop), .sample_irq_arm(sample_irq_arm),
  .frame_five_step(frame_five_step)
);

// File: tb/snd_len_status_bench.sv
`timescale 1ns/1ps
module snd_len_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       frame_irq_en = 1'b0;
  logic [4:0]  ch_active;
  logic [6:0]  tri_linear;
  logic        frame_irq, sample_irq_clr, sample_loop, sample_irq_arm, frame_five_step;
  logic [11:0] sample_period;

  always #10 clk = ~clk;

  snd_len_status u_snd_len_status (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_irq_en(frame_irq_en), .ch_active(ch_active), .tri_linear(tri_linear),
    .frame_irq(frame_irq), .sample_irq_clr(sample_irq_clr), .sample_period(sample_period),
    .sample_loop(sample_loop), .sample_irq_arm(sample_irq_arm), .frame_five_step(frame_five_step)
  );

  int checks = 0, bad = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  int len_tbl [32] = '{5,127,10,1,19,2,40,3,80,4,30,5,7,6,13,7,
                       6,8,12,9,24,10,48,11,96,12,36,13,8,14,16,15};
  int rate_tbl [16] = '{428,380,340,320,286,254,226,214,190,160,142,128,106,85,72,54};

  // reference model state
  int m_en [5], m_len [5], m_halt [5];
  int m_lin, m_relv, m_rel, m_status;
  int m_period, m_loop, m_arm, m_cache, m_rem, m_clr;
  int m_mode, m_stepc, m_firq;

  task automatic m_reset();
    for (int i = 0; i < 5; i++) begin m_en[i] = 0; m_len[i] = 0; m_halt[i] = 0; end
    m_lin = 0; m_relv = 0; m_rel = 0; m_status = 0;
    m_period = 0; m_loop = 0; m_arm = 0; m_cache = 0; m_rem = 0; m_clr = 0;
    m_mode = 0; m_stepc = 0; m_firq = 0;
  endtask

  task automatic m_step(input int b0);
    int nl;
    foreach (m_en[i]) begin
      if (i != 2 && i != 4 && m_en[i] != 0 && m_len[i] > 0 && m_halt[i] == 0 && b0 == 0)
        m_len[i]--;
    end
    if (m_en[2] != 0) begin
      if (m_halt[2] == 0 && b0 == 0 && m_len[2] > 0) m_len[2]--;
      nl = (m_rel != 0) ? m_relv : ((m_lin > 0) ? m_lin - 1 : 0);
      m_lin = nl;
      if (m_halt[2] == 0 && nl != 0) m_rel = 0;
    end
  endtask

  task automatic m_apply(input int a, input int d);
    int ch;
    case (a)
      0, 4, 12: m_halt[a/4] = (d >> 5) & 1;
      8: begin m_halt[2] = (d >> 7) & 1; m_relv = d & 127; end
      3, 7, 11, 15: begin
        ch = a / 4;
        m_len[ch] = 2 * len_tbl[d >> 3];
        if (((m_status >> ch) & 1) != 0) m_en[ch] = 1;
        if (ch == 2) m_rel = 1;
      end
      16: begin
        m_period = rate_tbl[d & 15] * 8;
        m_loop = (d >> 6) & 1; m_arm = (d >> 7) & 1;
        if (m_arm == 0) m_clr = 1;
      end
      19: m_cache = d * 16 + 1;
      21: begin
        m_status = d & 31;
        for (int c = 0; c < 4; c++)
          if (((d >> c) & 1) == 0) begin
            m_en[c] = 0; m_len[c] = 0;
            if (c == 2) begin m_lin = 0; m_rel = 0; end
          end
        if (((d >> 4) & 1) == 0) begin
          m_en[4] = 0; m_rem = 0; m_arm = 0; m_clr = 1;
        end else begin
          m_en[4] = 1;
          if (m_rem == 0) m_rem = m_cache;
        end
      end
      23: begin
        m_firq = 0; m_mode = (d >> 6) & 3; m_stepc = 1;
        if (((d >> 7) & 1) != 0) m_step(0);
      end
      24: begin
        if (m_stepc == 0 && m_mode == 0 && frame_irq_en) m_firq = 1;
        m_stepc = (m_stepc + 1) % 4;
        m_step(d & 1);
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) m_reset();
    else begin
      m_clr = 0;
      if (wr_en) m_apply(int'(wr_addr), int'(wr_data));
    end
  end

  task automatic chk(input string f, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, f, act, exp);
    end
  endtask

  function automatic int exp_active();
    int v = 0;
    for (int c = 0; c < 4; c++) if (m_en[c] != 0 && m_len[c] > 0) v |= (1 << c);
    if (m_en[4] != 0 && m_rem > 0) v |= 16;
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("ch_active", int'(ch_active), exp_active());
      chk("tri_linear", int'(tri_linear), m_lin);
      chk("frame_irq", int'(frame_irq), m_firq);
      chk("sample_irq_clr", int'(sample_irq_clr), m_clr);
      chk("sample_period", int'(sample_period), m_period);
      chk("sample_loop", int'(sample_loop), m_loop);
      chk("sample_irq_arm", int'(sample_irq_arm), m_arm);
      chk("frame_five_step", int'(frame_five_step), m_mode >> 1);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n, input logic b0);
    for (int i = 0; i < n; i++) wr(5'h18, {7'd0, b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1: reset state
    cur_req = "R1";
    chk("reset ch_active", int'(ch_active), 0);
    chk("reset frame_irq", int'(frame_irq), 0);
    chk("reset tri_linear", int'(tri_linear), 0);

    // R2: loads gated by the status mask
    cur_req = "R2";
    wr(5'h03, 8'h18);
    chk("pulse0 without mask", int'(ch_active[0]), 0);
    wr(5'h15, 8'h1F);
    wr(5'h03, 8'h18);
    chk("pulse0 armed", int'(ch_active[0]), 1);
    wr(5'h07, 8'h08);
    wr(5'h0F, 8'h20);
    wr(5'h0B, 8'h00);
    chk("noise armed", int'(ch_active[3]), 1);

    // R5: step gating by bit 0
    cur_req = "R5";
    step(2, 1'b1);
    chk("gated steps keep pulse0", int'(ch_active[0]), 1);
    step(2, 1'b0);
    chk("pulse0 ran out", int'(ch_active[0]), 0);

    // R4: halt bits
    cur_req = "R4";
    wr(5'h03, 8'h18);
    wr(5'h00, 8'h20);
    step(3, 1'b0);
    chk("halted pulse0 holds", int'(ch_active[0]), 1);
    wr(5'h00, 8'h00);
    step(2, 1'b0);
    chk("released pulse0 runs out", int'(ch_active[0]), 0);

    // R6: triangle linear counter
    cur_req = "R6";
    wr(5'h08, 8'h03);
    wr(5'h0B, 8'h08);
    step(1, 1'b0);
    chk("linear reload", int'(tri_linear), 3);
    step(4, 1'b0);
    chk("linear drains", int'(tri_linear), 0);
    wr(5'h08, 8'h85);
    wr(5'h0B, 8'h08);
    step(3, 1'b0);
    chk("halted linear pinned", int'(tri_linear), 5);
    wr(5'h08, 8'h05);
    step(2, 1'b0);

    // R3: status clears
    cur_req = "R3";
    wr(5'h15, 8'h1D);
    chk("pulse1 cleared", int'(ch_active[1]), 0);
    wr(5'h15, 8'h1B);
    chk("triangle cleared", int'(ch_active[2]), 0);
    chk("linear cleared", int'(tri_linear), 0);

    // R7 and R11: sample setup and clear pulse
    cur_req = "R7";
    wr(5'h10, 8'h4F);
    chk("period sel 15", int'(sample_period), 432);
    wr(5'h10, 8'h80);
    chk("period sel 0", int'(sample_period), 3424);
    cur_req = "R11";
    wr(5'h10, 8'h05);
    @(negedge clk);

    // R8: sample length
    cur_req = "R8";
    wr(5'h10, 8'h80);
    wr(5'h13, 8'h02);
    wr(5'h15, 8'h1F);
    chk("sample armed", int'(ch_active[4]), 1);
    wr(5'h13, 8'h05);
    wr(5'h15, 8'h1F);
    wr(5'h15, 8'h0F);
    chk("sample cleared", int'(ch_active[4]), 0);
    wr(5'h15, 8'h1F);
    chk("sample rearmed", int'(ch_active[4]), 1);

    // R10: frame interrupt
    cur_req = "R10";
    frame_irq_en = 1'b1;
    wr(5'h17, 8'h00);
    step(3, 1'b1);
    chk("no irq before step 0", int'(frame_irq), 0);
    step(1, 1'b1);
    chk("irq at step 0", int'(frame_irq), 1);
    cur_req = "R9";
    wr(5'h17, 8'h00);
    chk("irq cleared by mode write", int'(frame_irq), 0);
    cur_req = "R10";
    wr(5'h17, 8'h40);
    step(4, 1'b1);
    chk("inhibit bit blocks irq", int'(frame_irq), 0);
    frame_irq_en = 1'b0;
    wr(5'h17, 8'h00);
    step(4, 1'b1);
    chk("disabled irq", int'(frame_irq), 0);

    // R9: five-step immediate step
    cur_req = "R9";
    wr(5'h03, 8'h18);
    wr(5'h17, 8'h80);
    chk("five-step flag", int'(frame_five_step), 1);
    wr(5'h17, 8'h80);
    chk("two immediate steps drain pulse0", int'(ch_active[0]), 0);

    repeat (4) @(negedge clk);
    cmp_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule